// File: doc/BRIEF.md
# Blank Verify and Chip Erase Sequencer

This block is the operation controller behind a flash bus for two long-running jobs. The first checks that one block holds only erased words. The second erases every block in the array that is not protected. A small command decoder watches bus write cycles for the unlock-prefixed sequences that start either job. An operation engine then walks the array through a narrow per-block interface. That interface has a block index, a word index with a combinational read-back word, an erase request with a done pulse, and a protect vector with one bit per block.

While a job runs, the block raises `busy` and `status_sel`, and the read path shows the 8-bit status register in place of array data. Bit 6 of status is a toggle that flips on every bus read while busy. Bit 5 is the verify error flag. All other status bits read 0.

The command decoder has the states C_IDLE, C_U1 (first unlock seen), C_U2 (second unlock seen), C_E3 (erase setup seen), C_E4 and C_E5 (second unlock pair seen). It moves forward one state per matching write and drops back to C_IDLE on any other write.

The engine has the states S_READ (normal reads), S_VERIFY (one word checked per cycle), S_SCAN (look at the protect bit of the current block), S_ERASE (erase request held until done), S_PROT_WAIT (fixed window when every block is protected) and S_ERROR (verify failed, status held). Its transitions are:
- S_READ to S_VERIFY on a verify start.
- S_READ to S_SCAN on an erase start, or to S_PROT_WAIT if every block is protected.
- S_VERIFY to S_READ after the last word, or to S_ERROR on the first word that is not all ones.
- S_SCAN to S_ERASE for an unprotected block. For a protected block, S_SCAN moves to the next block, or to S_READ after the last one.
- S_ERASE to S_SCAN on done, or to S_READ on done for the last block.
- S_PROT_WAIT to S_READ when its timer expires.
- S_ERROR to S_READ on a reset command.

Top module: `blank_erase_seq`

## Requirements
- R1: Out of reset, `busy`, `status_sel` and `erase_req` are 0 and `status` is 8'h00.
- R2: The writes 8'hAA at low address 12'h555, then 8'h55 at 12'h2AA, then 8'h33 start a blank verify. The third write may use any low address, and its top address bits give the block number. A write that breaks the sequence returns the decoder to idle, so a later 8'h33 alone starts nothing.
- R3: While an operation runs, `busy` and `status_sel` are 1. Status bit 6 inverts on every cycle with `rd_en` high. Status bits 7 and 4..0 are always 0.
- R4: A verify passes only if all WORDS words of the block equal all ones. On a pass, `busy` is high for exactly WORDS cycles and the block returns to read mode (`status_sel` 0, bit 5 clear).
- R5: A verify that meets a non-blank word at index k ends after k+1 busy cycles with bit 5 set and `status_sel` held at 1. Bit 6 is frozen and every write other than 8'hF0 is ignored. A write of 8'hF0 clears the error and restores read mode.
- R6: Chip erase starts on six writes: 8'hAA@12'h555, 8'h55@12'h2AA, 8'h80@12'h555, 8'hAA@12'h555, 8'h55@12'h2AA, 8'h10@12'h555. Any wrong data or address in the sequence starts nothing.
- R7: Chip erase requests an erase for each unprotected block in ascending order and never for a protected one. Protected blocks keep their data, and no error bit is set.
- R8: If every block is protected, chip erase still raises `busy` for exactly ALLPROT_CYCLES cycles, issues no erase request and changes no data.
- R9: While an operation runs, every bus write is ignored, including 8'hF0. The running operation completes, and the decoder is idle afterwards.
- R10: In read mode, a write of 8'hF0 part-way through a sequence returns the decoder to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Bus write strobe, one cycle per write |
| wr_addr | input | ADDR_W | Bus write address: block number in the top bits, command address in the low 12 bits |
| wr_data | input | 8 | Bus write data (command code) |
| rd_en | input | 1 | Bus read strobe, drives the status toggle |
| protect | input | NUM_BLOCKS | One protect bit per block |
| arr_blk | output | BLK_W | Block index presented to the array |
| arr_word | output | WORD_W | Word index within the block for read-back |
| arr_rdata | input | DATA_W | Array word at arr_blk/arr_word, combinational |
| erase_req | output | 1 | Erase request for block arr_blk, held until done |
| erase_done | input | 1 | One-cycle pulse: requested block is erased |
| busy | output | 1 | An operation is running |
| status | output | 8 | Status register: bit 6 toggle, bit 5 verify error |
| status_sel | output | 1 | Read path shows status instead of array data |

## Verification
The hardest state to reach from the ports is a verify error that sits beside a sequence of ignored writes. To get there, a block must hold a non-blank word at a chosen index, the verify must stop exactly there, and writes that would otherwise start an operation must then be shown to do nothing. The bench seeds each block with either all-ones data or a single bad word at a random index, so the fail point is known. After a failure it replays full command sequences and checks that `status_sel`, `busy` and the frozen toggle stay put until 8'hF0 arrives. A second hard case is a write burst that lands mid-erase. The bench injects a reset command and a complete verify sequence while erase requests are in flight. It then checks that every unprotected block was still erased in order.

// File: rtl/bes_pkg.sv
package bes_pkg;

    localparam int CMD_AW = 12;

    localparam logic [CMD_AW-1:0] ADR_A = 12'h555;
    localparam logic [CMD_AW-1:0] ADR_B = 12'h2AA;

    localparam logic [7:0] K_UNLOCK1 = 8'hAA;
    localparam logic [7:0] K_UNLOCK2 = 8'h55;
    localparam logic [7:0] K_VERIFY  = 8'h33;
    localparam logic [7:0] K_SETUP   = 8'h80;
    localparam logic [7:0] K_CHIP    = 8'h10;
    localparam logic [7:0] K_RESET   = 8'hF0;

    typedef enum logic [2:0] {
        C_IDLE,
        C_U1,
        C_U2,
        C_E3,
        C_E4,
        C_E5
    } cmd_state_t;

    typedef enum logic [2:0] {
        S_READ,
        S_VERIFY,
        S_SCAN,
        S_ERASE,
        S_PROT_WAIT,
        S_ERROR
    } op_state_t;

endpackage

// File: rtl/bes_cmd_decode.sv
module bes_cmd_decode
    import bes_pkg::*;
#(
    parameter int BLK_W = 3,
    localparam int ADDR_W = BLK_W + CMD_AW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lock,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    output logic              go_verify,
    output logic              go_erase,
    output logic              go_reset,
    output logic [BLK_W-1:0]  vfy_blk
);

    cmd_state_t cur, nxt;

    logic [CMD_AW-1:0] low;
    logic at_a, at_b;

    assign low     = wr_addr[CMD_AW-1:0];
    assign at_a    = (low == ADR_A);
    assign at_b    = (low == ADR_B);
    assign vfy_blk = wr_addr[ADDR_W-1 -: BLK_W];

    always_ff @(posedge clk) begin
        if (!rst_n) cur <= C_IDLE;
        else        cur <= nxt;
    end

    always_comb begin
        nxt       = cur;
        go_verify = 1'b0;
        go_erase  = 1'b0;
        go_reset  = 1'b0;
        if (lock) begin
            nxt = C_IDLE;
        end else if (wr_en) begin
            if (wr_data == K_RESET) begin
                go_reset = 1'b1;
                nxt      = C_IDLE;
            end else begin
                unique case (cur)
                    C_IDLE: nxt = (wr_data == K_UNLOCK1 && at_a) ? C_U1 : C_IDLE;
                    C_U1:   nxt = (wr_data == K_UNLOCK2 && at_b) ? C_U2 : C_IDLE;
                    C_U2: begin
                        if (wr_data == K_VERIFY) begin
                            go_verify = 1'b1;
                            nxt       = C_IDLE;
                        end else if (wr_data == K_SETUP && at_a) begin
                            nxt = C_E3;
                        end else begin
                            nxt = C_IDLE;
                        end
                    end
                    C_E3:   nxt = (wr_data == K_UNLOCK1 && at_a) ? C_E4 : C_IDLE;
                    C_E4:   nxt = (wr_data == K_UNLOCK2 && at_b) ? C_E5 : C_IDLE;
                    C_E5: begin
                        go_erase = (wr_data == K_CHIP) && at_a;
                        nxt      = C_IDLE;
                    end
                    default: nxt = C_IDLE;
                endcase
            end
        end
    end

    // R9
    lock_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lock && wr_en) |=> (cur == C_IDLE));

endmodule

// File: rtl/bes_op_engine.sv
module bes_op_engine
    import bes_pkg::*;
#(
    parameter int NUM_BLOCKS     = 8,
    parameter int WORDS          = 16,
    parameter int DATA_W         = 16,
    parameter int ALLPROT_CYCLES = 20000,
    localparam int BLK_W  = $clog2(NUM_BLOCKS),
    localparam int WORD_W = $clog2(WORDS),
    localparam int TMR_W  = $clog2(ALLPROT_CYCLES + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  go_verify,
    input  logic                  go_erase,
    input  logic                  go_reset,
    input  logic [BLK_W-1:0]      vfy_blk,
    input  logic [NUM_BLOCKS-1:0] protect,
    input  logic [DATA_W-1:0]     arr_rdata,
    input  logic                  erase_done,
    output logic [BLK_W-1:0]      arr_blk,
    output logic [WORD_W-1:0]     arr_word,
    output logic                  erase_req,
    output logic                  busy,
    output logic                  status_sel,
    output logic                  err_set,
    output logic                  err_clr
);

    localparam logic [BLK_W-1:0]  LAST_BLK  = BLK_W'(NUM_BLOCKS - 1);
    localparam logic [WORD_W-1:0] LAST_WORD = WORD_W'(WORDS - 1);
    localparam logic [TMR_W-1:0]  LAST_TMR  = TMR_W'(ALLPROT_CYCLES - 1);

    op_state_t           state, state_n;
    logic [BLK_W-1:0]    blk, blk_n;
    logic [WORD_W-1:0]   word, word_n;
    logic [TMR_W-1:0]    tmr, tmr_n;
    logic                word_bad;

    assign word_bad = (arr_rdata != {DATA_W{1'b1}});

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= S_READ;
            blk   <= '0;
            word  <= '0;
            tmr   <= '0;
        end else begin
            state <= state_n;
            blk   <= blk_n;
            word  <= word_n;
            tmr   <= tmr_n;
        end
    end

    always_comb begin
        state_n = state;
        blk_n   = blk;
        word_n  = word;
        tmr_n   = tmr;
        err_set = 1'b0;
        err_clr = 1'b0;
        unique case (state)
            S_READ: begin
                if (go_verify) begin
                    state_n = S_VERIFY;
                    blk_n   = vfy_blk;
                    word_n  = '0;
                end else if (go_erase) begin
                    blk_n = '0;
                    tmr_n = '0;
                    state_n = (&protect) ? S_PROT_WAIT : S_SCAN;
                end
            end
            S_VERIFY: begin
                if (word_bad) begin
                    state_n = S_ERROR;
                    err_set = 1'b1;
                end else if (word == LAST_WORD) begin
                    state_n = S_READ;
                end else begin
                    word_n = word + 1'b1;
                end
            end
            S_SCAN: begin
                if (!protect[blk])        state_n = S_ERASE;
                else if (blk == LAST_BLK) state_n = S_READ;
                else                      blk_n   = blk + 1'b1;
            end
            S_ERASE: begin
                if (erase_done) begin
                    if (blk == LAST_BLK) begin
                        state_n = S_READ;
                    end else begin
                        state_n = S_SCAN;
                        blk_n   = blk + 1'b1;
                    end
                end
            end
            S_PROT_WAIT: begin
                if (tmr == LAST_TMR) state_n = S_READ;
                else                 tmr_n   = tmr + 1'b1;
            end
            S_ERROR: begin
                if (go_reset) begin
                    state_n = S_READ;
                    err_clr = 1'b1;
                end
            end
            default: state_n = S_READ;
        endcase
    end

    always_comb begin
        arr_blk    = blk;
        arr_word   = word;
        erase_req  = (state == S_ERASE);
        busy       = (state == S_VERIFY) || (state == S_SCAN) ||
                     (state == S_ERASE)  || (state == S_PROT_WAIT);
        status_sel = busy || (state == S_ERROR);
    end

    // R7
    no_prot_erase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        erase_req |-> !protect[arr_blk]);

    // R5
    err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_ERROR && !go_reset) |=> (state == S_ERROR));

    // R9
    erase_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (erase_req && !erase_done) |=> (erase_req && $stable(arr_blk)));

    // R8
    prot_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_PROT_WAIT) |-> (busy && !erase_req));

endmodule

// File: rtl/bes_status.sv
module bes_status (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       busy,
    input  logic       rd_en,
    input  logic       err_set,
    input  logic       err_clr,
    output logic [7:0] status
);

    logic tog, err;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tog <= 1'b0;
            err <= 1'b0;
        end else begin
            if (busy && rd_en) tog <= ~tog;
            if (err_set)       err <= 1'b1;
            else if (err_clr)  err <= 1'b0;
        end
    end

    assign status = {1'b0, tog, err, 5'b0};

    // R3
    toggle_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && rd_en) |=> (status[6] != $past(status[6])));

    // R5
    toggle_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> $stable(status[6]));

    // R5
    err_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_clr && !err_set) |=> !status[5]);

endmodule

// File: rtl/blank_erase_seq.sv
module blank_erase_seq
    import bes_pkg::*;
#(
    parameter int NUM_BLOCKS     = 8,
    parameter int WORDS          = 16,
    parameter int DATA_W         = 16,
    parameter int ALLPROT_CYCLES = 20000,
    localparam int BLK_W  = $clog2(NUM_BLOCKS),
    localparam int WORD_W = $clog2(WORDS),
    localparam int ADDR_W = BLK_W + CMD_AW
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [ADDR_W-1:0]     wr_addr,
    input  logic [7:0]            wr_data,
    input  logic                  rd_en,
    input  logic [NUM_BLOCKS-1:0] protect,
    output logic [BLK_W-1:0]      arr_blk,
    output logic [WORD_W-1:0]     arr_word,
    input  logic [DATA_W-1:0]     arr_rdata,
    output logic                  erase_req,
    input  logic                  erase_done,
    output logic                  busy,
    output logic [7:0]            status,
    output logic                  status_sel
);

    logic go_verify, go_erase, go_reset, err_set, err_clr;
    logic [BLK_W-1:0] vfy_blk;

    bes_cmd_decode #(.BLK_W(BLK_W)) dec_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .lock      (busy),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .go_verify (go_verify),
        .go_erase  (go_erase),
        .go_reset  (go_reset),
        .vfy_blk   (vfy_blk)
    );

    bes_op_engine #(
        .NUM_BLOCKS     (NUM_BLOCKS),
        .WORDS          (WORDS),
        .DATA_W         (DATA_W),
        .ALLPROT_CYCLES (ALLPROT_CYCLES)
    ) eng_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .go_verify  (go_verify),
        .go_erase   (go_erase),
        .go_reset   (go_reset),
        .vfy_blk    (vfy_blk),
        .protect    (protect),
        .arr_rdata  (arr_rdata),
        .erase_done (erase_done),
        .arr_blk    (arr_blk),
        .arr_word   (arr_word),
        .erase_req  (erase_req),
        .busy       (busy),
        .status_sel (status_sel),
        .err_set    (err_set),
        .err_clr    (err_clr)
    );

    bes_status st_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .busy    (busy),
        .rd_en   (rd_en),
        .err_set (err_set),
        .err_clr (err_clr),
        .status  (status)
    );

endmodule

// File: tb/blank_erase_seq_tb_top.sv
module blank_erase_seq_tb_top;

    localparam int NB = 8;
    localparam int W  = 16;
    localparam int DW = 16;
    localparam int AP = 40;
    localparam int BW = 3;
    localparam int WW = 4;
    localparam int AW = BW + 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic rd_en = 1'b0;
    logic [NB-1:0] protect = '0;
    logic [BW-1:0] arr_blk;
    logic [WW-1:0] arr_word;
    logic [DW-1:0] arr_rdata;
    logic erase_req;
    logic erase_done;
    logic busy, status_sel;
    logic [7:0] status;

    logic [DW-1:0] mem [NB*W];
    logic [DW-1:0] snap [NB*W];
    logic [2:0] er_cnt;
    int n_er;
    logic order_bad, have_prev, prot_hit;
    logic [BW-1:0] prev_blk;

    int n_chk = 0;
    int n_bad = 0;
    bit done_flag = 1'b0;

    always #2.5 clk = ~clk;

    blank_erase_seq #(.NUM_BLOCKS(NB), .WORDS(W), .DATA_W(DW), .ALLPROT_CYCLES(AP)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .protect(protect), .arr_blk(arr_blk), .arr_word(arr_word),
        .arr_rdata(arr_rdata), .erase_req(erase_req), .erase_done(erase_done),
        .busy(busy), .status(status), .status_sel(status_sel)
    );

    assign arr_rdata = mem[{arr_blk, arr_word}];

    // array model: erase takes three request cycles, then a done pulse
    always @(posedge clk) begin
        if (!rst_n) begin
            er_cnt <= '0;
            erase_done <= 1'b0;
        end else begin
            if (erase_req && protect[arr_blk]) prot_hit <= 1'b1;
            if (erase_done) begin
                erase_done <= 1'b0;
                er_cnt <= '0;
            end else if (erase_req) begin
                if (er_cnt == 3'd2) begin
                    erase_done <= 1'b1;
                    for (int w = 0; w < W; w++) mem[{arr_blk, WW'(w)}] <= '1;
                    if (have_prev && arr_blk <= prev_blk) order_bad <= 1'b1;
                    prev_blk <= arr_blk;
                    have_prev <= 1'b1;
                    n_er <= n_er + 1;
                end else begin
                    er_cnt <= er_cnt + 1'b1;
                end
            end
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!done_flag) begin
            done_flag = 1'b1;
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    endtask

    task automatic bus_wr(input logic [AW-1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    function automatic logic [AW-1:0] cmd_adr(input logic [11:0] low);
        return {BW'($urandom), low};
    endfunction

    task automatic seq_verify(input int b);
        bus_wr(cmd_adr(12'h555), 8'hAA);
        bus_wr(cmd_adr(12'h2AA), 8'h55);
        bus_wr({BW'(b), 12'($urandom)}, 8'h33);
    endtask

    task automatic seq_erase();
        bus_wr(cmd_adr(12'h555), 8'hAA);
        bus_wr(cmd_adr(12'h2AA), 8'h55);
        bus_wr(cmd_adr(12'h555), 8'h80);
        bus_wr(cmd_adr(12'h555), 8'hAA);
        bus_wr(cmd_adr(12'h2AA), 8'h55);
        bus_wr(cmd_adr(12'h555), 8'h10);
    endtask

    task automatic wait_idle(output int cyc);
        cyc = 0;
        while (busy && cyc < 5000) begin
            cyc++;
            @(negedge clk);
        end
    endtask

    // bad < 0: block all ones; else word bad gets value v
    task automatic fill_block(input int b, input int bad, input logic [DW-1:0] v);
        for (int w = 0; w < W; w++) mem[b*W + w] <= '1;
        if (bad >= 0) mem[b*W + bad] <= v;
        #1;
    endtask

    function automatic int first_bad(input int b);
        for (int w = 0; w < W; w++) if (mem[b*W + w] != '1) return w;
        return -1;
    endfunction

    task automatic clr_log();
        n_er <= 0; order_bad <= 1'b0; have_prev <= 1'b0; prot_hit <= 1'b0;
        #1;
    endtask

    task automatic take_snap();
        for (int i = 0; i < NB*W; i++) snap[i] = mem[i];
    endtask

    function automatic bit erase_ok();
        for (int b = 0; b < NB; b++) begin
            if (protect[b]) begin
                for (int w = 0; w < W; w++) if (mem[b*W+w] != snap[b*W+w]) return 1'b0;
            end else if (first_bad(b) != -1) return 1'b0;
        end
        return 1'b1;
    endfunction

    task automatic run_verify(input int b, input string tag);
        int cyc, fb;
        fb = first_bad(b);
        seq_verify(b);
        wait_idle(cyc);
        if (fb < 0) begin
            check(cyc == W, {tag, " verify pass duration"}, cyc, W);
            check(!status_sel && !status[5], {tag, " verify pass read mode"}, {status_sel, status[5]}, 0);
        end else begin
            check(cyc == fb + 1, {tag, " verify fail duration"}, cyc, fb + 1);
            check(status_sel && status[5], {tag, " verify fail error held"}, {status_sel, status[5]}, 3);
            bus_wr(cmd_adr(12'h0), 8'hF0);
            check(!status_sel && !status[5], "R5 reset clears error", {status_sel, status[5]}, 0);
        end
    endtask

    task automatic run_erase(input string tag);
        int cyc, exp_n;
        exp_n = NB - $countones(protect);
        take_snap();
        clr_log();
        seq_erase();
        wait_idle(cyc);
        check(erase_ok(), {tag, " erase data"}, 0, 1);
        check(n_er == exp_n && !order_bad && !prot_hit && !status[5] && !status_sel,
              {tag, " erase requests"}, n_er, exp_n);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog act=0 exp=1");
        summary();
    end

    initial begin
        int cyc;
        logic t0, t1;
        void'($urandom(32'd7321));
        for (int b = 0; b < NB; b++) fill_block(b, -1, '0);
        clr_log();
        repeat (3) @(negedge clk);
        // R1 reset state
        check(!busy && !status_sel && !erase_req && status == 8'h00, "R1 reset outputs",
              {busy, status_sel, erase_req, status}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !status_sel && status == 8'h00, "R1 after reset", {busy, status_sel, status}, 0);

        // R2 R4 blank block passes
        run_verify(2, "R2 R4");

        // R5 failing block, then ignored writes, frozen toggle
        fill_block(5, 7, 16'h1234);
        seq_verify(5);
        wait_idle(cyc);
        check(cyc == 8, "R5 fail at word 7 duration", cyc, 8);
        check(status_sel && !busy && status[5], "R5 error latched", {status_sel, busy, status[5]}, 5);
        t0 = status[6];
        seq_verify(2);
        seq_erase();
        check(status_sel && !busy && status[5], "R5 writes ignored in error", {status_sel, busy, status[5]}, 5);
        @(negedge clk); rd_en = 1'b1; @(negedge clk); rd_en = 1'b0; @(negedge clk);
        check(status[6] == t0, "R5 toggle frozen", status[6], t0);
        bus_wr(cmd_adr(12'h123), 8'hF0);
        check(!status_sel && !status[5], "R5 reset restores read", {status_sel, status[5]}, 0);
        fill_block(5, -1, '0);

        // R2 broken sequence
        bus_wr(cmd_adr(12'h555), 8'hAA);
        bus_wr(cmd_adr(12'h2AA), 8'h55);
        bus_wr(cmd_adr(12'h555), 8'h77);
        bus_wr({3'd1, 12'h0}, 8'h33);
        @(negedge clk);
        check(!busy && !status_sel, "R2 broken sequence starts nothing", busy, 0);
        // R10 reset mid sequence
        bus_wr(cmd_adr(12'h555), 8'hAA);
        bus_wr(cmd_adr(12'h2AA), 8'h55);
        bus_wr(cmd_adr(12'h2AA), 8'hF0);
        bus_wr({3'd1, 12'h0}, 8'h33);
        @(negedge clk);
        check(!busy && !status_sel, "R10 reset mid sequence", busy, 0);
        // R6 wrong address on fifth write
        bus_wr(cmd_adr(12'h555), 8'hAA);
        bus_wr(cmd_adr(12'h2AA), 8'h55);
        bus_wr(cmd_adr(12'h555), 8'h80);
        bus_wr(cmd_adr(12'h555), 8'hAA);
        bus_wr(cmd_adr(12'h555), 8'h55);
        bus_wr(cmd_adr(12'h555), 8'h10);
        @(negedge clk);
        check(!busy && !erase_req, "R6 bad erase sequence starts nothing", busy, 0);

        // R8 all protected
        protect = '1;
        fill_block(3, 2, 16'h0F0F);
        take_snap();
        clr_log();
        seq_erase();
        wait_idle(cyc);
        check(cyc == AP, "R8 all-protected window", cyc, AP);
        check(erase_ok() && n_er == 0 && !status[5], "R8 no data change", n_er, 0);

        // R3 toggle reads during the all-protected window
        seq_erase();
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            rd_en = 1'b1;
            t0 = status[6];
            check(status_sel && busy && (status & 8'h9F) == 8'h00, "R3 status while busy", status, 8'h00);
            @(negedge clk);
            rd_en = 1'b0;
            t1 = status[6];
            check(t1 != t0, "R3 toggle flips on read", t1, !t0);
        end
        wait_idle(cyc);

        // R7 R9 partial protect with writes during erase
        protect = 8'b1010_0101;
        for (int b = 0; b < NB; b++) fill_block(b, b % 4, 16'h00FF);
        take_snap();
        clr_log();
        seq_erase();
        bus_wr(cmd_adr(12'h0), 8'hF0);
        check(busy, "R9 F0 ignored during erase", busy, 1);
        seq_verify(0);
        check(busy, "R9 verify ignored during erase", busy, 1);
        wait_idle(cyc);
        check(erase_ok(), "R7 R9 erase data", 0, 1);
        check(n_er == 4 && !order_bad && !prot_hit && !status[5], "R7 erase requests", n_er, 4);
        bus_wr({3'd4, 12'h0}, 8'h33);
        @(negedge clk);
        check(!busy, "R9 decoder idle after erase", busy, 0);

        // random mix
        for (int it = 0; it < 40; it++) begin
            int b;
            protect = NB'($urandom);
            if ($urandom_range(0, 5) == 0) protect = '1;
            for (int k = 0; k < NB; k++) begin
                if ($urandom_range(0, 1) == 0) fill_block(k, -1, '0);
                else fill_block(k, $urandom_range(0, W - 1), DW'($urandom_range(0, 16'hFFFE)));
            end
            b = $urandom_range(0, NB - 1);
            if ($urandom_range(0, 1) == 0) run_verify(b, "R4 R5 random");
            else run_erase("R7 random");
        end

        summary();
    end

endmodule